// File: doc/BRIEF.md
# Event-Matrix PWM Timer

This block is a single up-counting timer. It has a bank of match registers, a set of events and a row of PWM outputs. Each event is programmed to watch one match register. The event fires on a count tick when the counter equals that match value. Each output has two event masks, one that drives it high and one that drives it low. A two-bit code per output settles the case where both masks hit in the same tick. A limit mask chooses which events send the counter back to zero. Every match register is shadowed by a reload register, which is copied into it when the counter wraps. All configuration goes through a write-only register port, and each write completes in one clock.

The timer runs under a three-state controller. `ST_IDLE` is entered at reset and is left only once the control register has been written. The transition idle-to-run is taken when that write leaves the halt bit clear. The transition idle-to-halt is taken when the write leaves the halt bit set. From `ST_RUN`, the transition run-to-halt is taken when the halt bit becomes set. From `ST_HALT`, the transition halt-to-run is taken when the halt bit is cleared. The prescaler and the counter move only in `ST_RUN`.

Typical use: one event, with its match set to N−1 and its bit set in the limit mask, defines an N-tick period. Further events define duty points. The set and clear masks then build normal or inverted waveforms from these events.

Top module: `evm_pwm_timer`

## Requirements
- R1: After reset every register is zero, the controller is in `ST_IDLE`, the counter does not move and all outputs are low. The controller leaves `ST_IDLE` one clock after the first write to the control register.
- R2: A write of `wr_data` at `wr_addr` lands in one clock at these byte offsets: config 0x000, control 0x004, limit 0x008, resolution 0x058, match n at 0x100+4n, reload n at 0x200+4n, event-control n at 0x304+8n, set mask n at 0x500+8n, clear mask n at 0x504+8n. A write to any other offset changes nothing.
- R3: An event fires only on a count tick, and only when its event-control bits 13:12 hold 1 (match mode) and the counter equals the match register named by bits 3:0. An event whose control value is 0, or whose mode field is not 1, never fires.
- R4: On a tick where any event selected by the limit mask (bit e = event e) fires, the counter goes to 0. On any other tick it goes up by one. A match value of N−1 on the limiting event therefore gives a period of N ticks.
- R5: Control bits 12:5 hold a prescale value P. In the run state a count tick occurs once every P+1 clocks.
- R6: Control bit 2 set halts the timer: the counter and every output hold their values. Clearing the bit resumes counting from where it stopped.
- R7: An output whose set mask (bit e = event e) catches a firing event, and whose clear mask catches none, is high after the next clock edge. The reverse case is low after the next edge. With no hit on either mask the output holds.
- R8: When set and clear hit output n in the same tick, the code in resolution bits 2n+1:2n decides the result: 0 holds, 1 sets, 2 clears, 3 toggles.
- R9: On a tick where the counter wraps, every match register takes its reload value, unless config bit 7 is set. A bus write to a match register in the same clock takes priority over the reload.
- R10: When a duty match equals the period match, an output with resolution code 1 stays high and an output with code 2 stays low.
- R11: With period match P−1 and duty match D, an output set by the period event and cleared by the duty event is high for D+1 of every P ticks. The inverted assignment is high for P−D−1 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| pwm_out | output | 16 | Registered PWM outputs |

## Verification
Several properties are checked on every cycle:
- the counter holds outside the run state, returns to zero after a limiting tick, and otherwise steps by one;
- the controller stays idle until the control register is written;
- ticks are spaced by the prescaler;
- the reload copy happens at the wrap;
- each output holds when none of its events fire, goes high after a set-only hit, and flips after a toggle conflict.

Only the bench scenarios can show the waveform-level results. These are the duty and period for the normal and inverted assignments, the constant high and low outputs when duty equals period, the stretched period under the prescaler, the frozen output during halt, the period change once the reload inhibit is lifted, and events with no valid setup having no effect.

// File: rtl/evm_pkg.sv
package evm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } run_st_t;

    typedef enum logic [1:0] {
        RES_HOLD   = 2'd0,
        RES_SET    = 2'd1,
        RES_CLEAR  = 2'd2,
        RES_TOGGLE = 2'd3
    } res_code_t;

    localparam int ADR_CFG      = 'h000;
    localparam int ADR_CTRL     = 'h004;
    localparam int ADR_LIMIT    = 'h008;
    localparam int ADR_RES      = 'h058;
    localparam int ADR_MATCH    = 'h100;
    localparam int ADR_RELOAD   = 'h200;
    localparam int ADR_EVCTL    = 'h304;
    localparam int ADR_OSET     = 'h500;
    localparam int ADR_OCLR     = 'h504;

    localparam int CFG_NOREL_BIT = 7;
    localparam int CTRL_HALT_BIT = 2;
    localparam int CTRL_PRE_LSB  = 5;
    localparam int EV_MODE_LSB   = 12;
    localparam logic [1:0] EV_MODE_MATCH = 2'd1;
endpackage

// File: rtl/evm_regs.sv
module evm_regs
    import evm_pkg::*;
#(
    parameter int N_EV    = 16,
    parameter int N_OUT   = 16,
    parameter int N_MATCH = 16,
    parameter int CW      = 32,
    parameter int PW      = 8,
    parameter int AW      = 12,
    parameter int DW      = 32,
    localparam int IW     = $clog2(N_MATCH)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [AW-1:0]                   wr_addr,
    input  logic [DW-1:0]                   wr_data,
    input  logic                            lim_tick,
    output logic                            norel_q,
    output logic                            halt_q,
    output logic                            seen_q,
    output logic [PW-1:0]                   pre_q,
    output logic [N_EV-1:0]                 limit_q,
    output logic [N_OUT-1:0][1:0]           res_q,
    output logic [N_MATCH-1:0][CW-1:0]      match_q,
    output logic [N_EV-1:0][IW-1:0]         ev_idx_q,
    output logic [N_EV-1:0][1:0]            ev_mode_q,
    output logic [N_OUT-1:0][N_EV-1:0]      set_q,
    output logic [N_OUT-1:0][N_EV-1:0]      clr_q
);
    logic [N_MATCH-1:0][CW-1:0] rel_q;
    logic [N_MATCH-1:0]         match_wr;
    logic                       unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        for (int m = 0; m < N_MATCH; m++)
            match_wr[m] = wr_en && (wr_addr == AW'(ADR_MATCH + 4 * m));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norel_q   <= 1'b0;
            halt_q    <= 1'b0;
            seen_q    <= 1'b0;
            pre_q     <= '0;
            limit_q   <= '0;
            res_q     <= '0;
            match_q   <= '0;
            rel_q     <= '0;
            ev_idx_q  <= '0;
            ev_mode_q <= '0;
            set_q     <= '0;
            clr_q     <= '0;
        end else begin
            if (wr_en && wr_addr == AW'(ADR_CFG))
                norel_q <= wr_data[CFG_NOREL_BIT];
            if (wr_en && wr_addr == AW'(ADR_CTRL)) begin
                halt_q <= wr_data[CTRL_HALT_BIT];
                pre_q  <= wr_data[CTRL_PRE_LSB +: PW];
                seen_q <= 1'b1;
            end
            if (wr_en && wr_addr == AW'(ADR_LIMIT))
                limit_q <= wr_data[N_EV-1:0];
            if (wr_en && wr_addr == AW'(ADR_RES))
                res_q <= wr_data[2*N_OUT-1:0];
            for (int m = 0; m < N_MATCH; m++) begin
                if (match_wr[m])
                    match_q[m] <= wr_data[CW-1:0];
                else if (lim_tick && !norel_q)
                    match_q[m] <= rel_q[m];
                if (wr_en && wr_addr == AW'(ADR_RELOAD + 4 * m))
                    rel_q[m] <= wr_data[CW-1:0];
            end
            for (int e = 0; e < N_EV; e++) begin
                if (wr_en && wr_addr == AW'(ADR_EVCTL + 8 * e)) begin
                    ev_idx_q[e]  <= wr_data[IW-1:0];
                    ev_mode_q[e] <= wr_data[EV_MODE_LSB +: 2];
                end
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (wr_en && wr_addr == AW'(ADR_OSET + 8 * o))
                    set_q[o] <= wr_data[N_EV-1:0];
                if (wr_en && wr_addr == AW'(ADR_OCLR + 8 * o))
                    clr_q[o] <= wr_data[N_EV-1:0];
            end
        end
    end

    generate
        for (genvar m = 0; m < N_MATCH; m++) begin : g_rel_chk
            // R9
            reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lim_tick && !norel_q && !match_wr[m] |=> match_q[m] == $past(rel_q[m]));
        end
    endgenerate
endmodule

// File: rtl/evm_counter.sv
module evm_counter
    import evm_pkg::*;
#(
    parameter int CW = 32,
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seen,
    input  logic          halt,
    input  logic [PW-1:0] prescale,
    input  logic          lim_hit,
    output logic [CW-1:0] cnt_q,
    output logic          tick
);
    run_st_t       st_q, st_d;
    logic [PW-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (seen) st_d = halt ? ST_HALT : ST_RUN;
            ST_RUN:  if (halt) st_d = ST_HALT;
            ST_HALT: if (!halt) st_d = ST_RUN;
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tick = (st_q == ST_RUN) && (pre_q >= prescale);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (st_q == ST_RUN) begin
            if (tick) begin
                pre_q <= '0;
                cnt_q <= lim_hit ? '0 : cnt_q + CW'(1);
            end else begin
                pre_q <= pre_q + PW'(1);
            end
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE && !seen |=> st_q == ST_IDLE);
    // R6
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != ST_RUN |=> $stable(cnt_q));
    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && lim_hit |=> cnt_q == '0);
    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !lim_hit |=> cnt_q == $past(cnt_q) + CW'(1));
    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick && prescale != '0 |=> !tick || prescale == '0);
endmodule

// File: rtl/evm_matrix.sv
module evm_matrix
    import evm_pkg::*;
#(
    parameter int N_EV    = 16,
    parameter int N_OUT   = 16,
    parameter int N_MATCH = 16,
    parameter int CW      = 32,
    localparam int IW     = $clog2(N_MATCH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic [CW-1:0]               cnt,
    input  logic [N_MATCH-1:0][CW-1:0]  match,
    input  logic [N_EV-1:0][IW-1:0]     ev_idx,
    input  logic [N_EV-1:0][1:0]        ev_mode,
    input  logic [N_EV-1:0]             limit,
    input  logic [N_OUT-1:0][N_EV-1:0]  set_mask,
    input  logic [N_OUT-1:0][N_EV-1:0]  clr_mask,
    input  logic [N_OUT-1:0][1:0]       res,
    output logic                        lim_hit,
    output logic [N_OUT-1:0]            pwm_q
);
    logic [N_EV-1:0]  ev_fire;
    logic [N_OUT-1:0] set_hit, clr_hit, pwm_d;

    always_comb begin
        for (int e = 0; e < N_EV; e++)
            ev_fire[e] = tick && (ev_mode[e] == EV_MODE_MATCH)
                         && (cnt == match[ev_idx[e]]);
        lim_hit = |(ev_fire & limit);
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            set_hit[o] = |(ev_fire & set_mask[o]);
            clr_hit[o] = |(ev_fire & clr_mask[o]);
            pwm_d[o]   = pwm_q[o];
            if (set_hit[o] && clr_hit[o]) begin
                unique case (res_code_t'(res[o]))
                    RES_HOLD:   pwm_d[o] = pwm_q[o];
                    RES_SET:    pwm_d[o] = 1'b1;
                    RES_CLEAR:  pwm_d[o] = 1'b0;
                    RES_TOGGLE: pwm_d[o] = !pwm_q[o];
                    default:    pwm_d[o] = pwm_q[o];
                endcase
            end else if (set_hit[o]) begin
                pwm_d[o] = 1'b1;
            end else if (clr_hit[o]) begin
                pwm_d[o] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= '0;
        else        pwm_q <= pwm_d;
    end

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out_chk
            // R7
            quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !set_hit[o] && !clr_hit[o] |=> $stable(pwm_q[o]));
            // R7
            set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_hit[o] && !clr_hit[o] |=> pwm_q[o]);
            // R8
            toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_hit[o] && clr_hit[o] && res[o] == 2'd3 |=> pwm_q[o] != $past(pwm_q[o]));
        end
    endgenerate
endmodule

// File: rtl/evm_pwm_timer.sv
module evm_pwm_timer
    import evm_pkg::*;
#(
    parameter int N_EV    = 16,
    parameter int N_OUT   = 16,
    parameter int N_MATCH = 16,
    parameter int CW      = 32,
    parameter int PW      = 8,
    parameter int AW      = 12,
    parameter int DW      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [N_OUT-1:0] pwm_out
);
    localparam int IW = $clog2(N_MATCH);

    logic                       norel, halt, seen, tick, lim_hit;
    logic [PW-1:0]              prescale;
    logic [CW-1:0]              cnt;
    logic [N_EV-1:0]            limit;
    logic [N_OUT-1:0][1:0]      res;
    logic [N_MATCH-1:0][CW-1:0] match;
    logic [N_EV-1:0][IW-1:0]    ev_idx;
    logic [N_EV-1:0][1:0]       ev_mode;
    logic [N_OUT-1:0][N_EV-1:0] set_mask, clr_mask;

    evm_regs #(
        .N_EV(N_EV), .N_OUT(N_OUT), .N_MATCH(N_MATCH),
        .CW(CW), .PW(PW), .AW(AW), .DW(DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .lim_tick(lim_hit), .norel_q(norel),
        .halt_q(halt), .seen_q(seen), .pre_q(prescale), .limit_q(limit),
        .res_q(res), .match_q(match), .ev_idx_q(ev_idx),
        .ev_mode_q(ev_mode), .set_q(set_mask), .clr_q(clr_mask)
    );

    evm_counter #(.CW(CW), .PW(PW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .seen(seen), .halt(halt),
        .prescale(prescale), .lim_hit(lim_hit), .cnt_q(cnt), .tick(tick)
    );

    evm_matrix #(
        .N_EV(N_EV), .N_OUT(N_OUT), .N_MATCH(N_MATCH), .CW(CW)
    ) u_mtx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .match(match),
        .ev_idx(ev_idx), .ev_mode(ev_mode), .limit(limit),
        .set_mask(set_mask), .clr_mask(clr_mask), .res(res),
        .lim_hit(lim_hit), .pwm_q(pwm_out)
    );
endmodule

// File: tb/tb_evm_pwm_timer.sv
module tb_evm_pwm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] pwm_out;

    int    vecs = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    evm_pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out)
    );

    // behavioural reference model
    logic [31:0] m_match [16];
    logic [31:0] m_rel   [16];
    int          m_idx   [16];
    int          m_mode  [16];
    logic [15:0] m_set   [16];
    logic [15:0] m_clr   [16];
    logic [15:0] m_lim, m_out, m_ev, m_nout;
    logic [31:0] m_res, m_cnt;
    bit          m_norel, m_halt, m_seen, m_tk, m_lh, m_s, m_c;
    int          m_pset, m_pre, m_state, m_next;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_match[i] = 0; m_rel[i] = 0; m_idx[i] = 0; m_mode[i] = 0;
                m_set[i] = 0; m_clr[i] = 0;
            end
            m_lim = 0; m_out = 0; m_res = 0; m_cnt = 0; m_norel = 0;
            m_halt = 0; m_seen = 0; m_pset = 0; m_pre = 0; m_state = 0;
        end else begin
            m_tk = (m_state == 1) && (m_pre >= m_pset);
            m_ev = 0;
            for (int e = 0; e < 16; e++)
                if (m_tk && m_mode[e] == 1 && m_cnt == m_match[m_idx[e]]) m_ev[e] = 1'b1;
            m_lh = (m_ev & m_lim) != 0;
            m_nout = m_out;
            for (int o = 0; o < 16; o++) begin
                m_s = (m_ev & m_set[o]) != 0;
                m_c = (m_ev & m_clr[o]) != 0;
                if (m_s && m_c) begin
                    case (m_res[2*o +: 2])
                        2'd1: m_nout[o] = 1'b1;
                        2'd2: m_nout[o] = 1'b0;
                        2'd3: m_nout[o] = !m_out[o];
                        default: ;
                    endcase
                end else if (m_s) m_nout[o] = 1'b1;
                else if (m_c) m_nout[o] = 1'b0;
            end
            m_out = m_nout;
            if (m_state == 1) begin
                if (m_tk) begin m_pre = 0; m_cnt = m_lh ? 0 : m_cnt + 1; end
                else m_pre = m_pre + 1;
            end
            if (m_lh && !m_norel)
                for (int i = 0; i < 16; i++) m_match[i] = m_rel[i];
            m_next = m_state;
            if (m_state == 0 && m_seen) m_next = m_halt ? 2 : 1;
            else if (m_state == 1 && m_halt) m_next = 2;
            else if (m_state == 2 && !m_halt) m_next = 1;
            m_state = m_next;
            if (wr_en) begin
                if (wr_addr == 12'h000) m_norel = wr_data[7];
                if (wr_addr == 12'h004) begin
                    m_halt = wr_data[2]; m_pset = int'(wr_data[12:5]); m_seen = 1;
                end
                if (wr_addr == 12'h008) m_lim = wr_data[15:0];
                if (wr_addr == 12'h058) m_res = wr_data;
                for (int i = 0; i < 16; i++) begin
                    if (wr_addr == 12'h100 + 12'(4*i)) m_match[i] = wr_data;
                    if (wr_addr == 12'h200 + 12'(4*i)) m_rel[i] = wr_data;
                    if (wr_addr == 12'h304 + 12'(8*i)) begin
                        m_idx[i] = int'(wr_data[3:0]); m_mode[i] = int'(wr_data[13:12]);
                    end
                    if (wr_addr == 12'h500 + 12'(8*i)) m_set[i] = wr_data[15:0];
                    if (wr_addr == 12'h504 + 12'(8*i)) m_clr[i] = wr_data[15:0];
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            vecs++;
            if (pwm_out !== m_out) begin
                fails++;
                $display("FAIL %s per-cycle model: actual %h expected %h", cur_req, pwm_out, m_out);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R2: one write per clock at the given byte offset
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_match(input int i, input logic [31:0] v);
        wr(12'h100 + 12'(4*i), v);
        wr(12'h200 + 12'(4*i), v);
    endtask

    int hi [16];
    int rs [16];

    task automatic measure(input int n);
        logic [15:0] prev;
        for (int o = 0; o < 16; o++) begin hi[o] = 0; rs[o] = 0; end
        @(negedge clk);
        prev = pwm_out;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            for (int o = 0; o < 16; o++) begin
                if (pwm_out[o]) hi[o]++;
                if (pwm_out[o] && !prev[o]) rs[o]++;
            end
            prev = pwm_out;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        logic [15:0] snap;
        idle(3);
        rst_n = 1'b1;
        idle(3);
        check("R1 reset outputs", int'(pwm_out), 0);
        cur_req = "R7";
        set_match(0, 9); set_match(1, 3); set_match(2, 9); set_match(5, 0);
        wr(12'h304, 32'h1000);           // ev0 -> match0
        wr(12'h30C, 32'h1001);           // ev1 -> match1
        wr(12'h314, 32'h1002);           // ev2 -> match2
        wr(12'h33C, 32'h2000);           // ev7 bad mode
        wr(12'h008, 32'h1);              // limit on ev0
        wr(12'h500, 32'h1); wr(12'h504, 32'h2);   // out0 normal
        wr(12'h508, 32'h2); wr(12'h50C, 32'h1);   // out1 inverted
        wr(12'h510, 32'h1); wr(12'h514, 32'h4);   // out2 duty=period, set
        wr(12'h518, 32'h4); wr(12'h51C, 32'h1);   // out3 duty=period, clear
        wr(12'h520, 32'h1); wr(12'h524, 32'h1);   // out4 toggle
        wr(12'h528, 32'h1); wr(12'h52C, 32'h1);   // out5 hold
        wr(12'h530, 32'h20);                      // out6 <- ev5 (ctrl 0)
        wr(12'h538, 32'h80);                      // out7 <- ev7
        wr(12'h058, 32'h399);
        idle(10);
        check("R1 idle until control written", int'(pwm_out), 0);
        wr(12'h004, 32'h0);
        idle(30);
        measure(40);
        check("R11 normal duty high ticks", hi[0], 16);
        check("R4 period rises", rs[0], 4);
        check("R11 inverted duty high ticks", hi[1], 24);
        check("R10 set code constant high", hi[2], 40);
        check("R10 clear code constant low", hi[3], 0);
        check("R8 toggle code", hi[4], 20);
        check("R8 hold code", hi[5], 0);
        check("R3 zero control no effect", hi[6], 0);
        check("R3 wrong mode no effect", hi[7], 0);
        check("R7 set/clear drive", rs[1], 4);

        wr(12'h004, 32'h1 << 5);
        idle(40);
        measure(80);
        check("R5 prescale normal high", hi[0], 32);
        check("R5 prescale inverted high", hi[1], 48);

        cur_req = "R6";
        wr(12'h004, 32'h4);
        idle(3);
        snap = pwm_out;
        idle(30);
        check("R6 halt freezes outputs", int'(pwm_out), int'(snap));
        wr(12'h004, 32'h0);
        idle(30);
        measure(40);
        check("R6 resume duty", hi[0], 16);

        cur_req = "R9";
        wr(12'h000, 32'h80);
        wr(12'h200, 32'd19);
        idle(40);
        measure(40);
        check("R9 reload inhibited", hi[0], 16);
        wr(12'h000, 32'h1);
        idle(40);
        measure(80);
        check("R9 reload period duty", hi[0], 16);
        check("R9 reload period rises", rs[0], 4);
        check("R9 reload inverted", hi[1], 64);

        cur_req = "R2";
        wr(12'h00C, 32'hFFFF_FFFF);
        idle(40);
        measure(80);
        check("R2 unmapped write ignored", hi[0], 16);
        check("R2 unmapped write ignored rises", rs[0], 4);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule